// File: doc/BRIEF.md
# Addressable I2C Bus-Segment Switch Controller

This block is the digital core of a two-wire bus bridge. It sits between an upstream I2C bus (for example a backplane) and a downstream bus segment (for example a plug-in card). A master on the upstream bus addresses the block as an I2C slave and writes a control byte and an output byte. Together these choose whether the downstream segment is joined to the upstream bus, which sides get rise-time assist, and how the two general-purpose pins behave.

The bus lines are modelled as open-drain signals. Each `*_i` line input is the level produced by the other devices on that side. Each `*_oe_o` output means the block pulls that line low. While the segment is linked, a low on either side is copied to the other side, so both sides see the wired-AND. Clock stretching, arbitration and acknowledge therefore pass through unchanged.

An enable input and a supply-good input each force the isolated default state. While the enable input is low, the slave interface is also silenced. A second supply-good input only breaks the link, and the link comes back when that supply recovers.

Top module: `i2c_seg_switch`

## Requirements
- R1: After reset the default state holds: the segment is unlinked, assist is off on both sides, both GPIOs are open-drain with the pull-down released (gpio_oe_o = 0), and a read returns control byte 0x00.
- R2: The slave answers only the 7-bit address {2'b11, strap_i}. A byte whose upper seven bits differ from this address is not acknowledged and changes nothing.
- R3: A write consists of the address with R/W = 0, a control byte and then an output byte. The control byte layout is: bit 7 link, bit 6 upstream assist (assist_up_o), bit 5 downstream assist (assist_dn_o), bits 3:2 GPIO0 mode, bits 1:0 GPIO1 mode. Bit 4 is unused.
- R4: While linked, a low on a line on one side makes the block pull the same line low on the other side. While unlinked, no line is propagated.
- R5: GPIO mode codes are as follows. 00 is open-drain: the pin pulls low when its output bit is 0 and is released when the bit is 1. 01 is push-pull: the pin drives its output bit. 10 and 11 are input: the pin is not driven. Bit i of the output byte is the value for GPIO i.
- R6: New settings take effect only when the acknowledge of the output byte completes. A STOP or repeated START after the control byte leaves all settings unchanged.
- R7: While en_i is low, the block returns to the default state within one clock and acknowledges nothing. When en_i rises again, the default state remains until a new write.
- R8: While pwr_ok_i is low, the block behaves exactly as it does while en_i is low.
- R9: While pwr2_ok_i is low, the link is broken and the settings are kept. The link resumes when pwr2_ok_i returns high.
- R10: A read (R/W = 1) returns the control byte first, with bit 4 as 0, and then a byte carrying the synchronized gpio_i levels in bits 1:0. The two bytes alternate for as long as the master acknowledges.
- R11: A data byte after the output byte in a write is not acknowledged, and it does not alter the settings already committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces default state and silences the slave |
| pwr_ok_i | input | 1 | Main supply good; low forces default state |
| pwr2_ok_i | input | 1 | Second supply good; low breaks the link |
| strap_i | input | 5 | Low five bits of the slave address |
| scl_up_i | input | 1 | Upstream clock level from other devices |
| sda_up_i | input | 1 | Upstream data level from other devices |
| scl_up_oe_o | output | 1 | Block pulls upstream clock low |
| sda_up_oe_o | output | 1 | Block pulls upstream data low |
| scl_dn_i | input | 1 | Downstream clock level from other devices |
| sda_dn_i | input | 1 | Downstream data level from other devices |
| scl_dn_oe_o | output | 1 | Block pulls downstream clock low |
| sda_dn_oe_o | output | 1 | Block pulls downstream data low |
| assist_up_o | output | 1 | Upstream rise-time assist enable |
| assist_dn_o | output | 1 | Downstream rise-time assist enable |
| gpio_i | input | 2 | GPIO pin levels |
| gpio_oe_o | output | 2 | GPIO driver enable |
| gpio_o | output | 2 | GPIO driven value |

## Verification
The bench builds the block with a two-stage synchronizer and the shortest legal glitch filter of two clocks. This keeps the input latency of the slave near four cycles, so that a bus quarter-period of twenty clocks leaves wide margins around every acknowledge and data bit. With the strap set to 10110, the bench can probe both near-miss addresses: one that differs only in the last strap bit, and one that differs only in the fixed prefix. These short timings leave room to cover aborted writes, over-long writes, both supply inputs and the enable input within one short run.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int NGPIO = 2;
    localparam logic [1:0] ADDR_PREFIX = 2'b11;

    localparam logic [1:0] GM_ODRAIN   = 2'b00;
    localparam logic [1:0] GM_PUSHPULL = 2'b01;

    typedef struct packed {
        logic                  link;
        logic                  asst_up;
        logic                  asst_dn;
        logic [NGPIO-1:0][1:0] mode;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } slv_st_e;

    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        return {c.link, c.asst_up, c.asst_dn, 1'b0, c.mode[0], c.mode[1]};
    endfunction

endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   filt;
        logic [CW-1:0]          cnt;
    } lc_t;

    lc_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], raw_i};
        if (s_q.sync[SYNC_STAGES-1] != s_q.filt) begin
            // accept a new level only after FILT_LEN steady cycles
            if (s_q.cnt == CW'(FILT_LEN - 1)) begin
                s_d.filt = s_q.sync[SYNC_STAGES-1];
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync <= '1;
            s_q.filt <= 1'b1;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign filt_o = s_q.filt;

endmodule

// File: rtl/i2cs_gpio_pad.sv
module i2cs_gpio_pad (
    input  logic [1:0] mode_i,
    input  logic       val_i,
    output logic       oe_o,
    output logic       o_o
);
    import i2cs_pkg::*;

    always_comb begin
        case (mode_i)
            GM_ODRAIN: begin
                oe_o = ~val_i;
                o_o  = 1'b0;
            end
            GM_PUSHPULL: begin
                oe_o = 1'b1;
                o_o  = val_i;
            end
            default: begin
                oe_o = 1'b0;
                o_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
    import i2cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [6:0]       dev_addr_i,
    input  logic [NGPIO-1:0] gpio_in_i,
    output logic             sda_drv_o,
    output ctl_t             ctl_o,
    output logic [NGPIO-1:0] gval_o
);
    typedef struct packed {
        slv_st_e          st;
        logic             prev_scl;
        logic             prev_sda;
        logic [3:0]       bitcnt;
        logic [7:0]       shift;
        logic             rw;
        logic [1:0]       idx;
        ctl_t             stage;
        logic             mack;
        logic             drv;
        ctl_t             ctl;
        logic [NGPIO-1:0] gval;
    } sl_t;

    sl_t s_q, s_d;

    logic       scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] ctl_byte, gpio_byte, next_byte;

    always_comb begin
        scl_rise  = scl_i & ~s_q.prev_scl;
        scl_fall  = ~scl_i & s_q.prev_scl;
        start_c   = s_q.prev_scl & scl_i & s_q.prev_sda & ~sda_i;
        stop_c    = s_q.prev_scl & scl_i & ~s_q.prev_sda & sda_i;
        ctl_byte  = ctl_to_byte(s_q.ctl);
        gpio_byte = {{(8-NGPIO){1'b0}}, gpio_in_i};
        next_byte = s_q.idx[0] ? ctl_byte : gpio_byte;

        s_d          = s_q;
        s_d.prev_scl = scl_i;
        s_d.prev_sda = sda_i;

        if (!active_i) begin
            s_d.st     = ST_IDLE;
            s_d.drv    = 1'b0;
            s_d.bitcnt = '0;
            s_d.idx    = '0;
            s_d.ctl    = CTL_DEFAULT;
            s_d.stage  = CTL_DEFAULT;
            s_d.gval   = '1;
        end else if (start_c) begin
            s_d.st     = ST_ADDR;
            s_d.bitcnt = '0;
            s_d.idx    = '0;
            s_d.drv    = 1'b0;
        end else if (stop_c) begin
            s_d.st  = ST_IDLE;
            s_d.drv = 1'b0;
        end else begin
            case (s_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        s_d.shift  = {s_q.shift[6:0], sda_i};
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end else if (scl_fall && s_q.bitcnt == 4'd8) begin
                        if (s_q.shift[7:1] == dev_addr_i) begin
                            s_d.rw  = s_q.shift[0];
                            s_d.drv = 1'b1;
                            s_d.st  = ST_AACK;
                        end else begin
                            s_d.st = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        s_d.bitcnt = '0;
                        if (s_q.rw) begin
                            s_d.shift = ctl_byte;
                            s_d.drv   = ~ctl_byte[7];
                            s_d.st    = ST_RDAT;
                        end else begin
                            s_d.drv = 1'b0;
                            s_d.st  = ST_WDAT;
                        end
                    end
                end
                ST_WDAT: begin
                    if (scl_rise) begin
                        s_d.shift  = {s_q.shift[6:0], sda_i};
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end else if (scl_fall && s_q.bitcnt == 4'd8) begin
                        if (s_q.idx != 2'd2) begin
                            s_d.drv = 1'b1;
                            s_d.st  = ST_WACK;
                        end else begin
                            s_d.st = ST_SKIP;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        s_d.drv    = 1'b0;
                        s_d.bitcnt = '0;
                        s_d.st     = ST_WDAT;
                        s_d.idx    = s_q.idx + 1'b1;
                        if (s_q.idx == 2'd0) begin
                            s_d.stage.link    = s_q.shift[7];
                            s_d.stage.asst_up = s_q.shift[6];
                            s_d.stage.asst_dn = s_q.shift[5];
                            s_d.stage.mode[0] = s_q.shift[3:2];
                            s_d.stage.mode[1] = s_q.shift[1:0];
                        end else begin
                            s_d.ctl  = s_q.stage;
                            s_d.gval = s_q.shift[NGPIO-1:0];
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        s_d.shift  = {s_q.shift[6:0], 1'b0};
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                        if (s_q.bitcnt == 4'd7) begin
                            s_d.drv = 1'b0;
                            s_d.st  = ST_RACK;
                        end else begin
                            s_d.drv = ~s_q.shift[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        s_d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        if (s_q.mack) begin
                            s_d.idx[0] = ~s_q.idx[0];
                            s_d.shift  = next_byte;
                            s_d.drv    = ~next_byte[7];
                            s_d.bitcnt = '0;
                            s_d.st     = ST_RDAT;
                        end else begin
                            s_d.drv = 1'b0;
                            s_d.st  = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.prev_scl <= 1'b1;
            s_q.prev_sda <= 1'b1;
            s_q.ctl      <= CTL_DEFAULT;
            s_q.stage    <= CTL_DEFAULT;
            s_q.gval     <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_drv_o = s_q.drv;
    assign ctl_o     = s_q.ctl;
    assign gval_o    = s_q.gval;

endmodule

// File: rtl/i2c_seg_switch.sv
module i2c_seg_switch
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pwr_ok_i,
    input  logic             pwr2_ok_i,
    input  logic [4:0]       strap_i,
    input  logic             scl_up_i,
    input  logic             sda_up_i,
    output logic             scl_up_oe_o,
    output logic             sda_up_oe_o,
    input  logic             scl_dn_i,
    input  logic             sda_dn_i,
    output logic             scl_dn_oe_o,
    output logic             sda_dn_oe_o,
    output logic             assist_up_o,
    output logic             assist_dn_o,
    input  logic [NGPIO-1:0] gpio_i,
    output logic [NGPIO-1:0] gpio_oe_o,
    output logic [NGPIO-1:0] gpio_o
);
    localparam int NLINES = 2;   // index 0 clock, 1 data

    typedef struct packed {
        logic [NGPIO-1:0] s1;
        logic [NGPIO-1:0] s2;
    } gs_t;

    gs_t              gs_q, gs_d;
    logic             active, link_eff, slv_drv;
    logic [NLINES-1:0] line_raw, line_filt;
    ctl_t             ctl;
    logic [NGPIO-1:0] gval;

    always_comb begin
        active      = en_i & pwr_ok_i;
        link_eff    = ctl.link & pwr2_ok_i & active;
        line_raw[0] = scl_up_i & (~link_eff | scl_dn_i);
        line_raw[1] = sda_up_i & (~link_eff | sda_dn_i);
        scl_up_oe_o = link_eff & ~scl_dn_i;
        scl_dn_oe_o = link_eff & ~scl_up_i;
        sda_up_oe_o = slv_drv | (link_eff & ~sda_dn_i);
        sda_dn_oe_o = link_eff & (~sda_up_i | slv_drv);
        assist_up_o = ctl.asst_up & active;
        assist_dn_o = ctl.asst_dn & active;
        gs_d.s1     = gpio_i;
        gs_d.s2     = gs_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gs_q <= '0;
        else        gs_q <= gs_d;
    end

    for (genvar gl = 0; gl < NLINES; gl++) begin : g_line
        i2cs_line_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (line_raw[gl]),
            .filt_o(line_filt[gl])
        );
    end

    i2cs_slave u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .scl_i     (line_filt[0]),
        .sda_i     (line_filt[1]),
        .dev_addr_i({ADDR_PREFIX, strap_i}),
        .gpio_in_i (gs_q.s2),
        .sda_drv_o (slv_drv),
        .ctl_o     (ctl),
        .gval_o    (gval)
    );

    for (genvar gp = 0; gp < NGPIO; gp++) begin : g_gpio
        i2cs_gpio_pad u_pad (
            .mode_i(ctl.mode[gp]),
            .val_i (gval[gp]),
            .oe_o  (gpio_oe_o[gp]),
            .o_o   (gpio_o[gp])
        );
    end

endmodule

// File: rtl/i2c_seg_switch_chk.sv
module i2c_seg_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       pwr_ok_i,
    input logic       pwr2_ok_i,
    input logic       scl_up_i,
    input logic       sda_up_i,
    input logic       scl_dn_i,
    input logic       scl_up_oe_o,
    input logic       sda_up_oe_o,
    input logic       scl_dn_oe_o,
    input logic       sda_dn_oe_o,
    input logic       assist_up_o,
    input logic       assist_dn_o,
    input logic [1:0] gpio_oe_o
);
    // R7
    en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!sda_up_oe_o && !scl_up_oe_o && !sda_dn_oe_o && !scl_dn_oe_o
                   && !assist_up_o && !assist_dn_o && gpio_oe_o == 2'b00));

    // R8
    pwr_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> (!sda_up_oe_o && !scl_up_oe_o && !sda_dn_oe_o && !scl_dn_oe_o
                       && !assist_up_o && !assist_dn_o && gpio_oe_o == 2'b00));

    // R9
    pwr2_unlink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr2_ok_i |-> (!scl_up_oe_o && !scl_dn_oe_o && !sda_dn_oe_o));

    // R4
    scl_up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_up_oe_o |-> !scl_dn_i);

    // R4
    scl_dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_dn_oe_o |-> !scl_up_i);

    // R4
    sda_dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_dn_oe_o |-> (!sda_up_i || sda_up_oe_o));

endmodule

bind i2c_seg_switch i2c_seg_switch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .pwr_ok_i   (pwr_ok_i),
    .pwr2_ok_i  (pwr2_ok_i),
    .scl_up_i   (scl_up_i),
    .sda_up_i   (sda_up_i),
    .scl_dn_i   (scl_dn_i),
    .scl_up_oe_o(scl_up_oe_o),
    .sda_up_oe_o(sda_up_oe_o),
    .scl_dn_oe_o(scl_dn_oe_o),
    .sda_dn_oe_o(sda_dn_oe_o),
    .assist_up_o(assist_up_o),
    .assist_dn_o(assist_dn_o),
    .gpio_oe_o  (gpio_oe_o)
);

// File: tb/tb_i2c_seg_switch.sv
module tb_i2c_seg_switch;
    localparam int Q = 20;
    localparam logic [7:0] AW = 8'hEC;   // {11,10110} + W
    localparam logic [7:0] AR = 8'hED;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, pok = 1'b1, pok2 = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, up_dev_sda = 1'b1;
    logic dn_dev_scl = 1'b1, dn_dev_sda = 1'b1;
    logic [1:0] gpio_in = 2'b00;
    logic scl_up, sda_up, line_sda;
    logic scl_up_oe, sda_up_oe, scl_dn_oe, sda_dn_oe, a_up, a_dn;
    logic [1:0] g_oe, g_o;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    assign scl_up   = m_scl;
    assign sda_up   = m_sda & up_dev_sda;
    assign line_sda = sda_up & ~sda_up_oe;

    i2c_seg_switch #(.SYNC_STAGES(2), .FILT_LEN(2)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .pwr_ok_i(pok), .pwr2_ok_i(pok2),
        .strap_i(5'b10110), .scl_up_i(scl_up), .sda_up_i(sda_up),
        .scl_up_oe_o(scl_up_oe), .sda_up_oe_o(sda_up_oe),
        .scl_dn_i(dn_dev_scl), .sda_dn_i(dn_dev_sda),
        .scl_dn_oe_o(scl_dn_oe), .sda_dn_oe_o(sda_dn_oe),
        .assist_up_o(a_up), .assist_dn_o(a_dn),
        .gpio_i(gpio_in), .gpio_oe_o(g_oe), .gpio_o(g_o));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = line_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~give_ack);
    endtask

    task automatic wr_regs(input logic [7:0] c, input logic [7:0] o);
        logic a0, a1, a2;
        i2c_start(); send_byte(AW, a0); send_byte(c, a1); send_byte(o, a2); i2c_stop();
        chk("R3 write acks", {a0, a1, a2}, 3'b111);
    endtask

    task automatic rd_regs(output logic [7:0] c, output logic [7:0] g);
        logic a;
        i2c_start(); send_byte(AR, a);
        recv_byte(1'b1, c); recv_byte(1'b0, g); i2c_stop();
        chk("R10 read addr ack", a, 1);
    endtask

    task automatic t_reset();
        logic [7:0] c, g;
        chk("R1 assist off", {a_up, a_dn}, 0);
        chk("R1 gpio released", {g_oe, g_o}, 0);
        dn_dev_sda = 1'b0; tick(2);
        chk("R1 unlinked", sda_up_oe, 0);
        dn_dev_sda = 1'b1; tick(2);
        rd_regs(c, g);
        chk("R1 control readback", c, 8'h00);
    endtask

    task automatic t_addr();
        logic a;
        i2c_start(); send_byte(8'hEE, a); i2c_stop();
        chk("R2 strap mismatch nack", a, 0);
        i2c_start(); send_byte(8'hAC, a); i2c_stop();
        chk("R2 prefix mismatch nack", a, 0);
        chk("R2 no change", {a_up, a_dn}, 0);
        i2c_start(); send_byte(AW, a); i2c_stop();
        chk("R2 match ack", a, 1);
    endtask

    task automatic t_write_read();
        logic [7:0] c, g;
        wr_regs(8'h60, 8'h03);
        chk("R3 assist both", {a_up, a_dn}, 2'b11);
        wr_regs(8'h40, 8'h03);
        chk("R3 assist up only", {a_up, a_dn}, 2'b10);
        wr_regs(8'h16, 8'h03);
        gpio_in = 2'b10; tick(4);
        rd_regs(c, g);
        chk("R10 bit4 reads zero", c, 8'h06);
        chk("R10 gpio input byte", g, 8'h02);
    endtask

    task automatic t_bridge();
        wr_regs(8'h80, 8'h03);
        dn_dev_scl = 1'b0; tick(2);
        chk("R4 dn clk low to up", scl_up_oe, 1);
        dn_dev_scl = 1'b1; tick(2);
        chk("R4 clk released", scl_up_oe, 0);
        dn_dev_sda = 1'b0; tick(2);
        chk("R4 dn data low to up", sda_up_oe, 1);
        dn_dev_sda = 1'b1; tick(8);
        up_dev_sda = 1'b0; tick(2);
        chk("R4 up data low to dn", sda_dn_oe, 1);
        up_dev_sda = 1'b1; tick(8);
        m_scl = 1'b0; tick(2);
        chk("R4 up clk low to dn", scl_dn_oe, 1);
        m_scl = 1'b1; tick(8);
        wr_regs(8'h00, 8'h03);
        dn_dev_scl = 1'b0; tick(2);
        chk("R4 unlinked isolation", scl_up_oe, 0);
        dn_dev_scl = 1'b1; tick(2);
    endtask

    task automatic t_gpio();
        wr_regs(8'h06, 8'h01);
        chk("R5 pushpull high, input", {g_oe, g_o}, 4'b0101);
        wr_regs(8'h06, 8'h00);
        chk("R5 pushpull low", {g_oe, g_o}, 4'b0100);
        wr_regs(8'h00, 8'h02);
        chk("R5 opendrain pull/release", {g_oe, g_o}, 4'b0100);
        wr_regs(8'h00, 8'h01);
        chk("R5 opendrain swapped", {g_oe, g_o}, 4'b1000);
    endtask

    task automatic t_partial();
        logic a0, a1, a2;
        logic [7:0] c, g;
        wr_regs(8'h20, 8'h03);
        i2c_start(); send_byte(AW, a0); send_byte(8'hC0, a1); i2c_stop();
        chk("R6 stop after ctl unchanged", {a_up, a_dn}, 2'b01);
        i2c_start(); send_byte(AW, a0); send_byte(8'hC0, a1);
        chk("R6 pending before output byte", {a_up, a_dn}, 2'b01);
        i2c_start(); send_byte(AR, a2);
        recv_byte(1'b0, c); i2c_stop();
        chk("R6 restart unchanged", c, 8'h20);
        i2c_start(); send_byte(AW, a0); send_byte(8'h40, a1); send_byte(8'h03, a2);
        chk("R6 commit after output ack", {a_up, a_dn}, 2'b10);
        i2c_stop();
        rd_regs(c, g);
        chk("R6 committed readback", c, 8'h40);
    endtask

    task automatic t_extra();
        logic a0, a1, a2, a3;
        logic [7:0] c, g;
        i2c_start(); send_byte(AW, a0); send_byte(8'h20, a1);
        send_byte(8'h03, a2); send_byte(8'hE0, a3); i2c_stop();
        chk("R11 third byte nack", a3, 0);
        rd_regs(c, g);
        chk("R11 settings from first two", c, 8'h20);
    endtask

    task automatic t_enable(input logic use_pwr, input string req);
        logic a;
        logic [7:0] c, g;
        wr_regs(8'hE0, 8'h00);
        if (use_pwr) pok = 1'b0; else en = 1'b0;
        tick(2);
        chk({req, " default assist"}, {a_up, a_dn}, 0);
        chk({req, " default gpio"}, g_oe, 0);
        i2c_start(); send_byte(AW, a); i2c_stop();
        chk({req, " silent"}, a, 0);
        pok = 1'b1; en = 1'b1; tick(4);
        chk({req, " stays default"}, {a_up, a_dn}, 0);
        rd_regs(c, g);
        chk({req, " readback default"}, c, 8'h00);
    endtask

    task automatic t_pwr2();
        wr_regs(8'hA0, 8'h03);
        pok2 = 1'b0; tick(2);
        dn_dev_scl = 1'b0; tick(2);
        chk("R9 link broken", scl_up_oe, 0);
        chk("R9 assist kept", a_dn, 1);
        pok2 = 1'b1; tick(2);
        chk("R9 link resumes", scl_up_oe, 1);
        dn_dev_scl = 1'b1; tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_addr();
        t_write_read();
        t_bridge();
        t_gpio();
        t_partial();
        t_extra();
        t_enable(1'b0, "R7");
        t_enable(1'b1, "R8");
        t_pwr2();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule